// File: doc/BRIEF.md
# Packed SIMD Integer and Complex Multiplier

This block multiplies two 32-bit packed operands. A mode input picks how the operands are read. It can treat them as one 32-bit number, as two 16-bit lanes, or as four 8-bit lanes. Each lane gets its own product, and a sign control selects two's-complement or unsigned arithmetic. The block can also read each operand as packed complex numbers: one element with 16-bit parts, or two elements with 8-bit parts. It then returns the complex product of each element pair. Every product is written at double width into a 64-bit result.

All modes share one datapath:
- A radix-4 Booth row generator that is cut at lane boundaries.
- A reduction tree of 3:2 cells and 4:2 compressors. Carries are blocked from crossing into the next lane.
- A carry-propagate adder split into 16-bit segments, whose segment carries are gated by the active mode.
- An output register that a parameter enables.

Top module: `simd_mul`

## Requirements
- R1: With `OUT_REG`=1, the operands and mode present at a rising clock edge determine `result` after that edge. A synchronous, active-high `rst` clears `result` to zero at the next edge.
- R2: With mode code 2, `result` is the full 64-bit product of `op_a` and `op_b`. The operands are two's-complement when `is_signed`=1 and unsigned when `is_signed`=0.
- R3: With mode code 1, lane i is `op_a[16i+15:16i]` times `op_b[16i+15:16i]` (i = 0, 1). The 32-bit product goes to `result[32i+31:32i]`, signed or unsigned as set by `is_signed`.
- R4: With mode code 0, lane i is `op_a[8i+7:8i]` times `op_b[8i+7:8i]` (i = 0..3). The 16-bit product goes to `result[16i+15:16i]`, signed or unsigned as set by `is_signed`.
- R5: In the split integer modes, no lane's result field is affected by another lane's operands. In particular, all-ones unsigned operands give 0xFE01 in every byte lane and 0xFFFE0001 in every halfword lane.
- R6: With mode code 4, each operand holds one complex number: real part in bits [15:0], imaginary part in bits [31:16]. The real part of the product (re·re − im·im, modulo 2^32) goes to `result[31:0]`. The imaginary part (re·im + im·re, modulo 2^32) goes to `result[63:32]`. All parts are two's-complement.
- R7: With mode code 3, element k (k = 0, 1) takes its real part from bits [16k+7:16k] and its imaginary part from bits [16k+15:16k+8]. The real product part, modulo 2^16, goes to `result[32k+15:32k]`. The imaginary product part, modulo 2^16, goes to `result[32k+31:32k+16]`.
- R8: In the complex modes `is_signed` has no effect. The parts are always two's-complement.
- R9: Mode codes 5, 6 and 7 are reserved and produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 32 | Packed multiplicand operand |
| op_b | input | 32 | Packed multiplier operand |
| mode | input | 3 | 0: 8-bit lanes, 1: 16-bit lanes, 2: one 32-bit product, 3: two 8-bit complex pairs, 4: one 16-bit complex pair, 5 to 7: reserved |
| is_signed | input | 1 | Two's-complement integer lanes when 1, unsigned when 0 |
| result | output | 64 | Packed double-width products |

## Verification
The hardest case to reach is a carry that runs to the top of a lane's result field, which the tree or the final adder must discard rather than pass into the neighbouring lane. That carry only appears when the partial products of a lane are mostly inverted rows or sign-extension ones. Plain random operands rarely fill every lane this way at once. The stimulus therefore sweeps every mode and both sign settings through a grid of lane-shaped corner operands: zero, all-ones, the most negative and the most positive value of 8-, 16- and 32-bit lanes. After the sweep it runs random operands and random mode codes, reserved codes included.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int OPW   = 32;
    localparam int RW    = 2 * OPW;
    localparam int NDIG  = OPW / 2 + 1;
    localparam int NROWS = NDIG + 2;
    localparam int MAXF  = OPW / 8;
    localparam int SEGW  = 16;
    localparam int NSEG  = RW / SEGW;

    typedef enum logic [2:0] {
        MD_I8  = 3'd0,
        MD_I16 = 3'd1,
        MD_I32 = 3'd2,
        MD_C8  = 3'd3,
        MD_C16 = 3'd4
    } mode_e;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdig_t;

    typedef struct packed {
        int   fw;
        int   nf;
        int   np;
        int   nd;
        int   esz;
        logic cpx;
    } geom_t;

    function automatic geom_t geom_of(mode_e m);
        geom_t g;
        g.cpx = 1'b0;
        g.np  = 1;
        case (m)
            MD_I8:   g.esz = 8;
            MD_I16:  g.esz = 16;
            MD_I32:  g.esz = 32;
            MD_C8:   begin g.esz = 8;  g.cpx = 1'b1; g.np = 2; end
            MD_C16:  begin g.esz = 16; g.cpx = 1'b1; g.np = 2; end
            default: g.esz = 8;
        endcase
        g.fw = 2 * g.esz;
        g.nf = (m inside {MD_I8, MD_I16, MD_I32, MD_C8, MD_C16}) ? RW / g.fw : 0;
        g.nd = g.cpx ? g.esz / 2 : g.esz / 2 + 1;
        return g;
    endfunction

    function automatic logic [RW-1:0] ext_op(logic [OPW-1:0] v, int w, logic sgn);
        logic [RW-1:0] r;
        for (int i = 0; i < RW; i++)
            r[i] = (i < w) ? v[i & (OPW-1)] : (sgn & v[w-1]);
        return r;
    endfunction

    function automatic bdig_t booth_dig(logic [OPW-1:0] y, int w, logic sgn, int k);
        logic [RW-1:0] ye;
        logic t2, t1, t0;
        bdig_t d;
        ye = ext_op(y, w, sgn);
        t2 = ye[2*k+1];
        t1 = ye[2*k];
        t0 = (k == 0) ? 1'b0 : ye[(2*k+RW-1) % RW];
        d.neg = t2 & ~(t1 & t0);
        d.one = t1 ^ t0;
        d.two = (t2 & ~t1 & ~t0) | (~t2 & t1 & t0);
        return d;
    endfunction

    function automatic logic [RW-1:0] pp_row(logic [OPW-1:0] x, int w, logic sgn,
                                             bdig_t d, int k, int fw);
        logic [RW-1:0] xe, mag, v, msk;
        xe  = ext_op(x, w, sgn);
        mag = d.one ? xe : (d.two ? (xe << 1) : '0);
        v   = d.neg ? ~mag : mag;
        v   = v << (2 * k);
        msk = (fw >= RW) ? '1 : ((RW'(1) << fw) - RW'(1));
        return v & msk;
    endfunction

    function automatic logic [NSEG-1:0] seg_kill(mode_e m);
        geom_t g;
        logic [NSEG-1:0] k;
        g = geom_of(m);
        for (int s = 0; s < NSEG; s++)
            k[s] = ((s * SEGW) % g.fw) == 0;
        return k;
    endfunction

    function automatic int tree_next(int n);
        return 2 * (n / 4) + (((n % 4) == 3) ? 2 : (n % 4));
    endfunction

    function automatic int tree_cnt(int n, int s);
        int c;
        c = n;
        for (int i = 0; i < s; i++) c = tree_next(c);
        return c;
    endfunction

    function automatic int tree_depth(int n);
        int c, d;
        c = n;
        d = 0;
        while (c > 2) begin
            c = tree_next(c);
            d++;
        end
        return d;
    endfunction

endpackage

// File: rtl/simd_mul_ppgen.sv
module simd_mul_ppgen
    import simd_mul_pkg::*;
(
    input  logic [OPW-1:0]             op_a,
    input  logic [OPW-1:0]             op_b,
    input  logic [2:0]                 mode,
    input  logic                       is_signed,
    output logic [NROWS-1:0][RW-1:0]   rows
);

    geom_t          g;
    logic [OPW-1:0] x, y;
    logic           sg, ng;
    bdig_t          d;
    int             base;

    always_comb begin
        g    = geom_of(mode_e'(mode));
        rows = '0;
        x    = '0;
        y    = '0;
        sg   = 1'b0;
        ng   = 1'b0;
        d    = '0;
        base = 0;
        for (int f = 0; f < MAXF; f++) begin
            for (int p = 0; p < 2; p++) begin
                if (f < g.nf && p < g.np) begin
                    if (!g.cpx) begin
                        x  = op_a >> (f * g.esz);
                        y  = op_b >> (f * g.esz);
                        sg = is_signed;
                        ng = 1'b0;
                    end else begin
                        base = (f / 2) * 2 * g.esz;
                        sg   = 1'b1;
                        x    = (p == 0) ? (op_a >> base) : (op_a >> (base + g.esz));
                        if ((f % 2) == 0) begin
                            // real field: re*re minus im*im
                            y  = (p == 0) ? (op_b >> base) : (op_b >> (base + g.esz));
                            ng = (p == 1);
                        end else begin
                            // imaginary field: re*im plus im*re
                            y  = (p == 0) ? (op_b >> (base + g.esz)) : (op_b >> base);
                            ng = 1'b0;
                        end
                    end
                    for (int k = 0; k < NDIG; k++) begin
                        if (k < g.nd) begin
                            d = booth_dig(y, g.esz, sg, k);
                            if (ng && (d.one || d.two)) d.neg = ~d.neg;
                            rows[p*g.nd+k] = rows[p*g.nd+k]
                                | (pp_row(x, g.esz, sg, d, k, g.fw) << (f * g.fw));
                            rows[NDIG+p][f*g.fw+2*k] = d.neg;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/simd_mul_csa32.sv
module simd_mul_csa32 #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    assign s  = a ^ b ^ c;
    assign cy = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/simd_mul_tree.sv
module simd_mul_tree
    import simd_mul_pkg::*;
#(
    parameter int N = NROWS,
    parameter int W = RW
) (
    input  logic [N-1:0][W-1:0] rows,
    input  logic [W-1:0]        kill,
    output logic [W-1:0]        sum_o,
    output logic [W-1:0]        carry_o
);
    localparam int D = tree_depth(N);

    logic [W-1:0] lv [0:D][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign lv[0][i] = rows[i];
    end

    for (genvar s = 0; s < D; s++) begin : g_stage
        localparam int CN = tree_cnt(N, s);
        localparam int NN = tree_cnt(N, s + 1);
        localparam int G4 = CN / 4;
        localparam int RM = CN % 4;

        for (genvar q = 0; q < G4; q++) begin : g_c42
            logic [W-1:0] s1, c1, c1k, s2, c2;
            simd_mul_csa32 #(.W(W)) u_lo (
                .a(lv[s][4*q]), .b(lv[s][4*q+1]), .c(lv[s][4*q+2]), .s(s1), .cy(c1));
            assign c1k = (c1 << 1) & ~kill;
            simd_mul_csa32 #(.W(W)) u_hi (
                .a(s1), .b(c1k), .c(lv[s][4*q+3]), .s(s2), .cy(c2));
            assign lv[s+1][2*q]   = s2;
            assign lv[s+1][2*q+1] = (c2 << 1) & ~kill;
        end

        if (RM == 3) begin : g_c32
            logic [W-1:0] s3, c3;
            simd_mul_csa32 #(.W(W)) u_fa (
                .a(lv[s][4*G4]), .b(lv[s][4*G4+1]), .c(lv[s][4*G4+2]), .s(s3), .cy(c3));
            assign lv[s+1][2*G4]   = s3;
            assign lv[s+1][2*G4+1] = (c3 << 1) & ~kill;
        end else begin : g_pass
            for (genvar r = 0; r < RM; r++) begin : g_r
                assign lv[s+1][2*G4+r] = lv[s][4*G4+r];
            end
        end

        for (genvar z = NN; z < N; z++) begin : g_zero
            assign lv[s+1][z] = '0;
        end
    end

    assign sum_o   = lv[D][0];
    assign carry_o = lv[D][1];

endmodule

// File: rtl/simd_mul_cpa.sv
module simd_mul_cpa #(
    parameter int W   = 64,
    parameter int SEG = 16
) (
    input  logic [W-1:0]       x,
    input  logic [W-1:0]       y,
    input  logic [W/SEG-1:0]   kseg,
    output logic [W-1:0]       sum
);
    localparam int NS = W / SEG;

    logic [NS:0] co;
    assign co[0] = 1'b0;

    for (genvar g = 0; g < NS; g++) begin : g_seg
        logic cin;
        assign cin = co[g] & ~kseg[g];
        assign {co[g+1], sum[g*SEG +: SEG]} =
            {1'b0, x[g*SEG +: SEG]} + {1'b0, y[g*SEG +: SEG]} + {{SEG{1'b0}}, cin};
    end

endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import simd_mul_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    input  logic [2:0]      mode,
    input  logic            is_signed,
    output logic [RW-1:0]   result
);

    logic [NROWS-1:0][RW-1:0] rows;
    logic [NSEG-1:0]          kseg;
    logic [RW-1:0]            kill;
    logic [RW-1:0]            t_sum, t_car, prod;

    assign kseg = seg_kill(mode_e'(mode));

    always_comb begin
        kill = '0;
        for (int s = 1; s < NSEG; s++) kill[s*SEGW] = kseg[s];
    end

    simd_mul_ppgen u_pp (
        .op_a(op_a), .op_b(op_b), .mode(mode), .is_signed(is_signed), .rows(rows));

    simd_mul_tree #(.N(NROWS), .W(RW)) u_tree (
        .rows(rows), .kill(kill), .sum_o(t_sum), .carry_o(t_car));

    simd_mul_cpa #(.W(RW), .SEG(SEGW)) u_cpa (
        .x(t_sum), .y(t_car), .kseg(kseg), .sum(prod));

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) result <= '0;
            else     result <= prod;
        end
    end else begin : g_comb
        assign result = prod;
    end

endmodule

// File: rtl/simd_mul_chk.sv
module simd_mul_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [2:0]  mode,
    input logic        is_signed,
    input logic [63:0] result
);

    function automatic logic [63:0] ref_of(logic [31:0] a, logic [31:0] b,
                                           logic [2:0] m, logic s);
        logic [63:0] r;
        longint xr, xi, yr, yi, p, q;
        r = '0;
        case (m)
            3'd0: for (int l = 0; l < 4; l++) begin
                xr = s ? longint'($signed(a[8*l +: 8])) : longint'({56'd0, a[8*l +: 8]});
                yr = s ? longint'($signed(b[8*l +: 8])) : longint'({56'd0, b[8*l +: 8]});
                p  = xr * yr;
                r[16*l +: 16] = p[15:0];
            end
            3'd1: for (int l = 0; l < 2; l++) begin
                xr = s ? longint'($signed(a[16*l +: 16])) : longint'({48'd0, a[16*l +: 16]});
                yr = s ? longint'($signed(b[16*l +: 16])) : longint'({48'd0, b[16*l +: 16]});
                p  = xr * yr;
                r[32*l +: 32] = p[31:0];
            end
            3'd2: begin
                xr = s ? longint'($signed(a)) : longint'({32'd0, a});
                yr = s ? longint'($signed(b)) : longint'({32'd0, b});
                p  = xr * yr;
                r  = p;
            end
            3'd3: for (int k = 0; k < 2; k++) begin
                xr = longint'($signed(a[16*k +: 8]));
                xi = longint'($signed(a[16*k+8 +: 8]));
                yr = longint'($signed(b[16*k +: 8]));
                yi = longint'($signed(b[16*k+8 +: 8]));
                p  = xr * yr - xi * yi;
                q  = xr * yi + xi * yr;
                r[32*k +: 16]    = p[15:0];
                r[32*k+16 +: 16] = q[15:0];
            end
            3'd4: begin
                xr = longint'($signed(a[15:0]));
                xi = longint'($signed(a[31:16]));
                yr = longint'($signed(b[15:0]));
                yi = longint'($signed(b[31:16]));
                p  = xr * yr - xi * yi;
                q  = xr * yi + xi * yr;
                r[31:0]  = p[31:0];
                r[63:32] = q[31:0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    logic [63:0] exp_c, exp_s;
    logic [2:0]  md_s;
    logic [31:0] a_s;
    logic        ok_s;

    assign exp_c = ref_of(op_a, op_b, mode, is_signed);

    if (OUT_REG) begin : g_seq
        logic [63:0] exp_q;
        logic [2:0]  mode_q;
        logic [31:0] a_q;
        logic        vld_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                exp_q  <= '0;
                mode_q <= '0;
                a_q    <= '0;
                vld_q  <= 1'b0;
            end else begin
                exp_q  <= exp_c;
                mode_q <= mode;
                a_q    <= op_a;
                vld_q  <= 1'b1;
            end
        end
        assign exp_s = exp_q;
        assign md_s  = mode_q;
        assign a_s   = op_a_hold(a_q);
        assign ok_s  = vld_q;

        // R1
        rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (result == 64'd0));
    end else begin : g_cmb
        assign exp_s = exp_c;
        assign md_s  = mode;
        assign a_s   = op_a;
        assign ok_s  = 1'b1;
    end

    function automatic logic [31:0] op_a_hold(logic [31:0] v);
        return v;
    endfunction

    // R2
    i32_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s == 3'd2) |-> (result == exp_s));
    // R3
    i16_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s == 3'd1) |-> (result == exp_s));
    // R4
    i8_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s == 3'd0) |-> (result == exp_s));
    // R5
    lane_iso_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s == 3'd0 && a_s[31:8] == 24'd0) |-> (result[63:16] == 48'd0));
    // R6
    c16_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s == 3'd4) |-> (result == exp_s));
    // R7
    c8_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s == 3'd3) |-> (result == exp_s));
    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ok_s && md_s >= 3'd5) |-> (result == 64'd0));

endmodule

bind simd_mul simd_mul_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .mode(mode), .is_signed(is_signed), .result(result));

// File: tb/simd_mul_bench.sv
`timescale 1ns/1ps
module simd_mul_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  mode = '0;
    logic        is_signed = 1'b0;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [63:0] v;
        string       tag;
    } exp_t;
    exp_t pend[$];

    always #2.5 clk = ~clk;

    simd_mul u_simd_mul (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .mode(mode), .is_signed(is_signed), .result(result));

    function automatic logic [63:0] model(logic [31:0] a, logic [31:0] b,
                                          logic [2:0] m, logic s);
        logic [63:0] r;
        longint ar, ai, br, bi, p, q;
        r = '0;
        if (m == 3'd2) begin
            ar = s ? longint'($signed(a)) : longint'({32'd0, a});
            br = s ? longint'($signed(b)) : longint'({32'd0, b});
            p  = ar * br;
            r  = p;
        end else if (m == 3'd1) begin
            for (int l = 0; l < 2; l++) begin
                ar = s ? longint'($signed(a[16*l +: 16])) : longint'({48'd0, a[16*l +: 16]});
                br = s ? longint'($signed(b[16*l +: 16])) : longint'({48'd0, b[16*l +: 16]});
                p  = ar * br;
                r[32*l +: 32] = p[31:0];
            end
        end else if (m == 3'd0) begin
            for (int l = 0; l < 4; l++) begin
                ar = s ? longint'($signed(a[8*l +: 8])) : longint'({56'd0, a[8*l +: 8]});
                br = s ? longint'($signed(b[8*l +: 8])) : longint'({56'd0, b[8*l +: 8]});
                p  = ar * br;
                r[16*l +: 16] = p[15:0];
            end
        end else if (m == 3'd4) begin
            ar = longint'($signed(a[15:0]));  ai = longint'($signed(a[31:16]));
            br = longint'($signed(b[15:0]));  bi = longint'($signed(b[31:16]));
            p  = ar * br - ai * bi;
            q  = ar * bi + ai * br;
            r  = {q[31:0], p[31:0]};
        end else if (m == 3'd3) begin
            for (int k = 0; k < 2; k++) begin
                ar = longint'($signed(a[16*k +: 8]));   ai = longint'($signed(a[16*k+8 +: 8]));
                br = longint'($signed(b[16*k +: 8]));   bi = longint'($signed(b[16*k+8 +: 8]));
                p  = ar * br - ai * bi;
                q  = ar * bi + ai * br;
                r[32*k +: 32] = {q[15:0], p[15:0]};
            end
        end
        return r;
    endfunction

    function automatic string tag_of(logic [31:0] a, logic [31:0] b, logic [2:0] m, logic s);
        if ((m == 3'd3 || m == 3'd4) && !s) return "R8";
        if ((m == 3'd0 || m == 3'd1) && !s && a == '1 && b == '1) return "R5";
        case (m)
            3'd0: return "R4";
            3'd1: return "R3";
            3'd2: return "R2";
            3'd3: return "R7";
            3'd4: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check_pending();
        exp_t e;
        if (pend.size() > 0) begin
            e = pend.pop_front();
            checks++;
            if (result !== e.v) begin
                errors++;
                $display("FAIL %s result=%h expected=%h", e.tag, result, e.v);
            end
        end
    endtask

    task automatic step(logic [31:0] a, logic [31:0] b, logic [2:0] m, logic s, logic r);
        exp_t e;
        @(negedge clk);
        check_pending();
        op_a = a; op_b = b; mode = m; is_signed = s; rst = r;
        if (r) begin
            e.v = '0; e.tag = "R1";
        end else begin
            e.v = model(a, b, m, s); e.tag = tag_of(a, b, m, s);
        end
        pend.push_back(e);
    endtask

    logic [31:0] corners [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                                 32'h8000_8000, 32'h7FFF_7FFF, 32'h8080_8080, 32'h7F7F_7F7F};

    initial begin
        // R1: reset holds result at zero even with operands applied
        for (int i = 0; i < 3; i++) step(32'hFFFF_FFFF, 32'h8000_0001, 3'd2, 1'b1, 1'b1);

        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        step(corners[i], corners[j], 3'(m), 1'(s), 1'b0);

        for (int n = 0; n < 2000; n++)
            step($urandom, $urandom, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'b0);

        // R1: reset in the middle of traffic
        step(32'hDEAD_BEEF, 32'h1234_5678, 3'd2, 1'b0, 1'b0);
        step(32'hDEAD_BEEF, 32'h1234_5678, 3'd2, 1'b0, 1'b1);
        step(32'h0102_0304, 32'hFFFF_FF80, 3'd0, 1'b1, 1'b0);
        step(32'h0102_0304, 32'hFFFF_FF80, 3'd4, 1'b1, 1'b0);
        @(negedge clk);
        check_pending();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired result=%h expected=finished run", result);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule